// File: doc/BRIEF.md
# Table pointer program-memory access unit

This block moves single bytes between a byte-addressed program memory and an 8-bit holding latch, under the control of a 21-bit table pointer. A command names a direction and one of four pointer-update modes. A read copies the addressed program-memory byte into the latch. A write copies the latch out to program memory at the addressed byte. The pointer can stay where it is, step up after the access, step down after the access, or step up before the access so that the new address is the one used.

Commands arrive on a valid/ready stream. `cmd_ready` is high only while the unit is idle, and a command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. A producer that is held off keeps `cmd_valid` and the command fields steady until the transfer happens.

After a transfer the unit runs a fixed two-cycle sequence with `busy` high: first an address cycle, then a data cycle. Program memory is a plain synchronous byte port. It captures `mem_we` and `mem_wdata` at the end of the address cycle, and it returns `mem_rdata` for the presented address during the following cycle. A small register port lets software load the three pointer bytes and the latch while the unit is idle.

Top module: `tblptr_access`

## Requirements
- R1: While reset is asserted, and straight after it is released, the pointer and the latch read zero, and `busy` and `mem_we` are low.
- R2: `cmd_ready` equals the inverse of `busy`. A command transfers only on an edge where `cmd_valid` and `cmd_ready` are both high. After a transfer, `busy` is high for exactly two cycles (address cycle, then data cycle). A command held valid while busy is taken only once the unit is idle again.
- R3: For a read (`cmd_write`=0), `mem_addr` carries the access address during the address cycle and `mem_we` stays low. At the edge that ends the data cycle, the latch takes the value on `mem_rdata`.
- R4: For a write (`cmd_write`=1), `mem_we` is high during the address cycle only, with `mem_addr` equal to the access address and `mem_wdata` equal to the latch. The latch is not changed by the command.
- R5: Mode 0 (`cmd_mode`=2'b00) accesses the pointer address and leaves the pointer unchanged.
- R6: Mode 1 (2'b01) accesses the pointer address and then adds one to the pointer at the edge that ends the data cycle.
- R7: Mode 2 (2'b10) accesses the pointer address and then subtracts one from the pointer at the edge that ends the data cycle.
- R8: Mode 3 (2'b11) adds one to the pointer at the transfer edge and accesses the new address.
- R9: Pointer steps wrap modulo 2^21: 0x1FFFFF plus one gives 0, and 0 minus one gives 0x1FFFFF.
- R10: A register-port write (`reg_we`=1) takes effect at the next edge. `reg_sel` 0 loads pointer bits 7:0 from `reg_wdata`. `reg_sel` 1 loads pointer bits 15:8. `reg_sel` 2 loads pointer bits 20:16 from `reg_wdata[4:0]`. `reg_sel` 3 loads the latch.
- R11: A register-port write is ignored when `busy` is high, and also on the edge where a command transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_write | input | 1 | 1 = latch to memory, 0 = memory to latch |
| cmd_mode | input | 2 | Pointer-update mode (0 hold, 1 post-increment, 2 post-decrement, 3 pre-increment) |
| busy | output | 1 | Command sequence in progress |
| reg_we | input | 1 | Register-port write strobe |
| reg_sel | input | 2 | Register-port target (0..2 pointer bytes, 3 latch) |
| reg_wdata | input | 8 | Register-port write data |
| ptr_q | output | 21 | Current table pointer |
| latch_q | output | 8 | Current table latch |
| mem_addr | output | 21 | Program-memory byte address |
| mem_we | output | 1 | Program-memory write enable |
| mem_wdata | output | 8 | Program-memory write data |
| mem_rdata | input | 8 | Program-memory read data, one cycle after the address |

## Verification
The cases that are hardest to reach are the pointer crossing the top of its 21-bit range in each direction. From reset this would take millions of steps. The stimulus instead loads 0x1FFFFE through the three register-port byte writes, and then runs post-increment writes, post-decrement reads and pre-increment reads that step across the 0x1FFFFF/0 boundary both ways.

Collisions are forced deliberately. A register write is issued during each of the two busy cycles. A command is held valid through a busy period. A command transfer and a register write share the same edge. A behavioural reference model, driven by the same inputs, predicts every output on every cycle.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD     = 2'd0,
    UPD_POST_INC = 2'd1,
    UPD_POST_DEC = 2'd2,
    UPD_PRE_INC  = 2'd3
  } upd_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/tblx_seq.sv
module tblx_seq
  import tblx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid,
  input  logic      cmd_write,
  input  upd_mode_e cmd_mode,
  output logic      accept,
  output logic      busy,
  output logic      addr_ph,
  output logic      data_ph,
  output logic      op_write,
  output upd_mode_e op_mode
);
  phase_e phase;

  assign accept  = cmd_valid && (phase == PH_IDLE);
  assign addr_ph = (phase == PH_ADDR);
  assign data_ph = (phase == PH_DATA);
  assign busy    = addr_ph || data_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      op_write <= 1'b0;
      op_mode  <= UPD_HOLD;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase    <= PH_ADDR;
          op_write <= cmd_write;
          op_mode  <= cmd_mode;
        end
        PH_ADDR: phase <= PH_DATA;
        PH_DATA: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |=> data_ph); // R2
  AST_DATA_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_ph |=> !busy); // R2
  AST_START_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid)); // R2
endmodule

// File: rtl/tblx_ptr.sv
module tblx_ptr
  import tblx_pkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  upd_mode_e         acc_mode,
  input  logic              addr_ph,
  input  logic              data_ph,
  input  upd_mode_e         op_mode,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [PTR_W-1:0]  ptr
);
  localparam int NLANE = (PTR_W + DATA_W - 1) / DATA_W;
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] wr_img;
  logic [PTR_W-1:0] nxt;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LO = g * DATA_W;
    localparam int HI = ((g + 1) * DATA_W > PTR_W) ? PTR_W : (g + 1) * DATA_W;
    assign wr_img[HI-1:LO] = (reg_sel == SEL_W'(g)) ? reg_wdata[HI-LO-1:0] : ptr[HI-1:LO];
  end

  always_comb begin
    nxt = ptr;
    if (accept) begin
      if (acc_mode == UPD_PRE_INC) nxt = ptr + ONE;
    end else if (data_ph) begin
      if (op_mode == UPD_POST_INC) nxt = ptr + ONE;
      else if (op_mode == UPD_POST_DEC) nxt = ptr - ONE;
    end else if (reg_wr) begin
      nxt = wr_img;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= nxt;
  end

  AST_PTR_STEADY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |=> $stable(ptr)); // R11
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && op_mode == UPD_HOLD) |=> $stable(ptr)); // R5
  AST_POST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && op_mode == UPD_POST_INC) |=> (ptr == $past(ptr) + ONE)); // R6
  AST_POST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && op_mode == UPD_POST_DEC) |=> (ptr == $past(ptr) - ONE)); // R7
endmodule

// File: rtl/tblx_latch.sv
module tblx_latch #(
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 2,
  parameter int LATCH_SEL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] rdata,
  input  logic              reg_wr,
  input  logic              data_ph,
  input  logic              op_write,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] latch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   latch <= '0;
    else if (load)                                latch <= rdata;
    else if (reg_wr && reg_sel == SEL_W'(LATCH_SEL)) latch <= reg_wdata;
  end

  AST_LATCH_KEEP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && op_write) |=> $stable(latch)); // R4
  AST_LATCH_TAKES_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && !op_write) |=> (latch == $past(rdata))); // R3
endmodule

// File: rtl/tblptr_access.sv
module tblptr_access
  import tblx_pkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8,
  localparam int NLANE = (PTR_W + DATA_W - 1) / DATA_W,
  localparam int SEL_W = $clog2(NLANE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_mode,
  output logic              busy,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [DATA_W-1:0] latch_q,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic      accept, addr_ph, data_ph, op_write, reg_wr;
  upd_mode_e op_mode;
  upd_mode_e in_mode;

  assign in_mode = upd_mode_e'(cmd_mode);

  tblx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_mode(in_mode), .accept(accept), .busy(busy), .addr_ph(addr_ph),
    .data_ph(data_ph), .op_write(op_write), .op_mode(op_mode)
  );

  assign reg_wr = reg_we && !busy && !accept;

  tblx_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .acc_mode(in_mode),
    .addr_ph(addr_ph), .data_ph(data_ph), .op_mode(op_mode), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ptr(ptr_q)
  );

  tblx_latch #(.DATA_W(DATA_W), .SEL_W(SEL_W), .LATCH_SEL(NLANE)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(data_ph && !op_write), .rdata(mem_rdata),
    .reg_wr(reg_wr), .data_ph(data_ph), .op_write(op_write), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .latch(latch_q)
  );

  assign cmd_ready = !busy;
  assign mem_addr  = ptr_q;
  assign mem_wdata = latch_q;
  assign mem_we    = addr_ph && op_write;

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R4
  AST_REG_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_sel == SEL_W'(NLANE) && !data_ph) |=> $stable(latch_q)); // R11
endmodule

// File: tb/tb_tblptr_access.sv
module tb_tblptr_access;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready, cmd_write, busy, reg_we, mem_we;
  logic [1:0]  cmd_mode, reg_sel;
  logic [7:0]  reg_wdata, latch_q, mem_wdata, mem_rdata;
  logic [20:0] ptr_q, mem_addr;

  tblptr_access dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_mode(cmd_mode), .busy(busy), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ptr_q(ptr_q), .latch_q(latch_q),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int nchk = 0, nerr = 0;
  bit started = 0;

  // program memory environment
  logic [7:0] mem [int];
  function automatic logic [7:0] mem_rd(int a);
    bit [31:0] v = a;
    if (mem.exists(a)) return mem[a];
    return v[7:0] ^ v[15:8] ^ {3'b0, v[20:16]} ^ 8'h5A;
  endfunction
  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= mem_rd(int'(mem_addr));
  end

  // behavioural reference
  localparam int MASK = 'h1FFFFF;
  int ph_m = 0, mw_m = 0, mm_m = 0, ptr_m = 0, lat_m = 0, aaddr_m = 0;
  string ptag = "R1", ltag = "R1", atag = "R3";

  function automatic string mode_tag(int m);
    case (m)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_m = 0; ptr_m = 0; lat_m = 0; ptag = "R1"; ltag = "R1";
    end else begin
      case (ph_m)
        0: if (cmd_valid) begin
             mw_m = cmd_write; mm_m = cmd_mode; ph_m = 1;
             atag = mw_m ? "R4" : mode_tag(mm_m);
             if (reg_we) begin ptag = "R11"; ltag = "R11"; end
             if (mm_m == 3) begin
               ptag = (ptr_m == MASK) ? "R9" : "R8";
               ptr_m = (ptr_m + 1) & MASK;
             end
             aaddr_m = ptr_m;
           end else if (reg_we) begin
             ptag = "R10"; ltag = "R10";
             case (reg_sel)
               2'd0: ptr_m = (ptr_m & ~'hFF) | int'(reg_wdata);
               2'd1: ptr_m = (ptr_m & ~'hFF00) | (int'(reg_wdata) << 8);
               2'd2: ptr_m = (ptr_m & 'hFFFF) | (int'(reg_wdata[4:0]) << 16);
               default: lat_m = reg_wdata;
             endcase
           end
        1: begin
             ph_m = 2;
             if (reg_we) begin ptag = "R11"; ltag = "R11"; end
           end
        default: begin
             ph_m = 0;
             if (reg_we) begin ptag = "R11"; ltag = "R11"; end
             if (mw_m == 0) begin lat_m = mem_rd(aaddr_m); ltag = "R3"; end
             else ltag = "R4";
             if (mm_m == 1) begin
               ptag = (ptr_m == MASK) ? "R9" : "R6";
               ptr_m = (ptr_m + 1) & MASK;
             end else if (mm_m == 2) begin
               ptag = (ptr_m == 0) ? "R9" : "R7";
               ptr_m = (ptr_m - 1) & MASK;
             end else if (mm_m == 0) ptag = "R5";
           end
      endcase
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R2", "busy", int'(busy), int'(ph_m != 0));
    chk("R2", "cmd_ready", int'(cmd_ready), int'(ph_m == 0));
    chk(mw_m ? "R4" : "R3", "mem_we", int'(mem_we), int'(ph_m == 1 && mw_m == 1));
    if (ph_m == 1) begin
      chk(atag, "mem_addr", int'(mem_addr), aaddr_m);
      if (mw_m == 1) chk("R4", "mem_wdata", int'(mem_wdata), lat_m);
    end
    chk(ptag, "ptr_q", int'(ptr_q), ptr_m);
    chk(ltag, "latch_q", int'(latch_q), lat_m);
  end

  task automatic regw(int sel, int val);
    reg_we = 1; reg_sel = 2'(sel); reg_wdata = 8'(val);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic cmd(int w, int m);
    cmd_valid = 1; cmd_write = w[0]; cmd_mode = 2'(m);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_mode = 0;
    reg_we = 0; reg_sel = 0; reg_wdata = 0;
    idle(2);
    started = 1;
    idle(2);                                   // R1 reset state compared
    rst_n = 1;
    idle(2);
    // R10 load pointer near the top, then the latch
    regw(0, 'hFE); regw(1, 'hFF); regw(2, 'h1F); regw(3, 'hA5);
    // R4 R6 R9 post-increment writes across the wrap
    cmd(1, 1); idle(2); cmd(1, 1); idle(2); cmd(1, 1); idle(2);
    regw(3, 'h3C);
    cmd(1, 0); idle(2);                        // R5
    // R3 R7 R9 post-decrement reads back across the wrap
    cmd(0, 2); idle(2); cmd(0, 2); idle(2); cmd(0, 2); idle(2);
    // R8 R9 pre-increment reads
    cmd(0, 3); idle(2); cmd(0, 3); idle(2); cmd(0, 3); idle(2);
    cmd(0, 0); idle(2);
    // R11 register writes during both busy cycles
    cmd(0, 1); regw(3, 'h77); regw(0, 'h11); idle(2);
    // R2 command held valid through a busy period
    cmd(1, 2); cmd(0, 1); idle(3);
    // R11 register write on the transfer edge
    cmd_valid = 1; cmd_write = 0; cmd_mode = 0; reg_we = 1; reg_sel = 0; reg_wdata = 'h42;
    @(negedge clk);
    cmd_valid = 0; reg_we = 0;
    idle(3);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) regw($urandom_range(0, 3), $urandom_range(0, 255));
      else if (op < 8) begin
        cmd($urandom_range(0, 1), $urandom_range(0, 3));
        if ($urandom_range(0, 1) == 1) regw($urandom_range(0, 3), $urandom_range(0, 255));
      end else idle($urandom_range(1, 3));
      if (i % 50 == 0) begin regw(0, 'hFF); regw(1, 'hFF); regw(2, 'h1F); end
    end
    idle(4);
    finish_run();
  end
endmodule